// File: doc/BRIEF.md
# Stateful Implication Logic Executor

This block emulates, in ordinary flip-flops, a small array of two-state cells that compute only by overwriting one another. Each cell holds one bit. The lowest cells are input cells, and a host loads them in parallel. The rest are working cells. The host sends a stream of micro-operation words, one per handshake. Each word executes as one pulse. A clear operation forces a cell to 0. An implication operation takes a source cell and a target cell and replaces the target with (NOT source) OR target. The source cell does not change.

Every result is produced in place and destroys an operand. A program therefore has to preset its working cells and plan around values it overwrites. Clear and implication together can build any Boolean function. For example, NOT takes one working cell and two pulses, and a two-input NAND takes one working cell and three pulses. A read operation returns any cell to the host. The block also keeps two cost figures. The first is a saturating pulse count, which stands for delay. The second is the area: the number of input cells plus the number of distinct working cells written since the last clear.

Operation word layout, 10 bits with the defaults: bits [9:8] opcode, bits [7:4] source index, bits [3:0] target index. Opcode values: 00 no-op, 01 clear, 10 implication, 11 read.

Top module: `imply_exec`

## Requirements
- R1: After reset, every cell reads 0, the pulse count is 0, the area equals the number of input cells (4), rd_valid_o is 0 and op_ready_o is 1.
- R2: An accepted clear (opcode 01) writes 0 into the target cell.
- R3: An accepted implication (opcode 10) with a source holding 0 writes 1 into the target. With a source holding 1, the target keeps its value. The source cell is never changed.
- R4: An implication whose source index equals its target index leaves that cell at 1, whatever its previous value.
- R5: An accepted no-op (opcode 00) or read (opcode 11) changes no cell and does not change the pulse count.
- R6: An accepted read of cell q drives rd_valid_o high for one cycle, starting on the edge after acceptance, with rd_data_o equal to the value cell q held before that edge.
- R7: Each accepted clear or implication adds exactly one to pulse_cnt_o.
- R8: pulse_cnt_o saturates at 65535 and stays there while pulses continue.
- R9: A cycle with cnt_clr_i high sets pulse_cnt_o to 0 and the area back to the input-cell count, without touching any cell.
- R10: area_o equals 4 plus the number of distinct working cells (indices 4 to 15) that were the target of a clear or implication since reset or the last cnt_clr_i. Writes to input cells do not add to it.
- R11: While load_en_i is high, op_ready_o is low and no operation is accepted. The edge loads load_data_i bit i into input cell i.
- R12: The NOT (2 pulses), NAND (3 pulses), OR (7 pulses) and XOR (12 pulses) programs give the Boolean result for all four input patterns. Each leaves the pulse count equal to its program length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_en_i | input | 1 | Load the input cells this cycle |
| load_data_i | input | 4 | Values for the input cells, bit i goes to cell i |
| cnt_clr_i | input | 1 | Synchronous clear of the pulse count and the area record |
| op_valid_i | input | 1 | An operation word is presented |
| op_ready_o | output | 1 | The block accepts an operation this cycle |
| op_word_i | input | 10 | Operation word {opcode, source index, target index} |
| rd_valid_o | output | 1 | Read data is valid |
| rd_data_o | output | 1 | Value of the cell that was read |
| pulse_cnt_o | output | 16 | Saturating count of clear and implication pulses |
| area_o | output | 5 | Input cells plus working cells used |

## Verification
The cell bank is visible only through reads. A corrupted cell therefore shows up on rd_data_o on the edge after the next read that addresses it. The programs read every result straight after its last pulse, so a wrong next-state rule appears within one program of 2 to 12 pulses. A faulty pulse or area record shows on pulse_cnt_o or area_o on the edge after the operation that should have moved it. Saturation is driven past its limit so that a wrapping counter shows up at once.

// File: rtl/imply_pkg.sv
package imply_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_CLR = 2'b01,
    OP_IMP = 2'b10,
    OP_RD  = 2'b11
  } op_e;
endpackage

// File: rtl/imply_decode.sv
module imply_decode
  import imply_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int OP_W = 2 + 2 * IDX_W
) (
  input  logic             op_valid_i,
  input  logic             op_ready_i,
  input  logic [OP_W-1:0]  op_word_i,
  output logic [IDX_W-1:0] p_idx_o,
  output logic [IDX_W-1:0] q_idx_o,
  output logic             clr_o,
  output logic             imp_o,
  output logic             rd_o,
  output logic             pulse_o
);
  op_e  opc;
  logic fire;

  assign opc     = op_e'(op_word_i[OP_W-1 -: 2]);
  assign p_idx_o = op_word_i[2*IDX_W-1 -: IDX_W];
  assign q_idx_o = op_word_i[IDX_W-1:0];
  assign fire    = op_valid_i && op_ready_i;

  always_comb begin
    clr_o = 1'b0;
    imp_o = 1'b0;
    rd_o  = 1'b0;
    if (fire) begin
      unique case (opc)
        OP_CLR:  clr_o = 1'b1;
        OP_IMP:  imp_o = 1'b1;
        OP_RD:   rd_o  = 1'b1;
        default: ;
      endcase
    end
  end

  assign pulse_o = clr_o | imp_o;
endmodule

// File: rtl/imply_bank.sv
module imply_bank #(
  parameter int N_CELLS = 16,
  parameter int N_IN    = 4,
  localparam int IDX_W  = $clog2(N_CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [N_IN-1:0]  load_data_i,
  input  logic             clr_i,
  input  logic             imp_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] p_idx_i,
  input  logic [IDX_W-1:0] q_idx_i,
  output logic             rd_valid_o,
  output logic             rd_data_o
);
  logic [N_CELLS-1:0] cells_q, cells_d;
  logic               src_bit;
  logic               rd_valid_q, rd_data_q;

  assign src_bit = cells_q[p_idx_i];

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    logic hit;
    logic op_nxt;
    assign hit    = (q_idx_i == IDX_W'(g));
    // implication overwrites target with !src | target
    assign op_nxt = clr_i ? 1'b0
                  : (imp_i ? (~src_bit | cells_q[g]) : cells_q[g]);
    if (g < N_IN) begin : g_in
      assign cells_d[g] = load_en_i ? load_data_i[g]
                        : (hit ? op_nxt : cells_q[g]);
    end else begin : g_wk
      assign cells_d[g] = hit ? op_nxt : cells_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cells_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= 1'b0;
    end else begin
      cells_q    <= cells_d;
      rd_valid_q <= rd_i;
      if (rd_i) rd_data_q <= cells_q[q_idx_i];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  p_false_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cells_q[$past(q_idx_i)] == 1'b0);

  p_imply_force_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imp_i && !src_bit) |=> cells_q[$past(q_idx_i)] == 1'b1);

  p_imply_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imp_i && src_bit && (p_idx_i != q_idx_i))
      |=> cells_q[$past(q_idx_i)] == $past(cells_q[q_idx_i]));

  p_src_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imp_i && (p_idx_i != q_idx_i)) |=> cells_q[$past(p_idx_i)] == $past(src_bit));

  p_self_imply_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imp_i && (p_idx_i == q_idx_i)) |=> cells_q[$past(q_idx_i)] == 1'b1);

  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !imp_i && !load_en_i) |=> $stable(cells_q));
endmodule

// File: rtl/imply_meter.sv
module imply_meter #(
  parameter int N_CELLS = 16,
  parameter int N_IN    = 4,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(N_CELLS),
  localparam int AREA_W = $clog2(N_CELLS + 1),
  localparam int N_WORK = N_CELLS - N_IN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_clr_i,
  input  logic              pulse_i,
  input  logic [IDX_W-1:0]  q_idx_i,
  output logic [CNT_W-1:0]  pulse_cnt_o,
  output logic [AREA_W-1:0] area_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q;
  logic [N_WORK-1:0] used_q, used_d;
  logic [AREA_W-1:0] area;

  for (genvar w = 0; w < N_WORK; w++) begin : g_use
    assign used_d[w] = used_q[w] | (pulse_i && (q_idx_i == IDX_W'(N_IN + w)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      used_q <= '0;
    end else if (cnt_clr_i) begin
      cnt_q  <= '0;
      used_q <= '0;
    end else begin
      used_q <= used_d;
      if (pulse_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    area = AREA_W'(N_IN);
    for (int i = 0; i < N_WORK; i++) area = area + AREA_W'(used_q[i]);
  end

  assign pulse_cnt_o = cnt_q;
  assign area_o      = area;

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !cnt_clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !cnt_clr_i) |=> cnt_q == CNT_MAX);

  p_cnt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_q == '0 && area_o == AREA_W'(N_IN)));

  p_area_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (area_o >= AREA_W'(N_IN)) && (area_o <= AREA_W'(N_CELLS)));
endmodule

// File: rtl/imply_exec.sv
module imply_exec #(
  parameter int N_CELLS = 16,
  parameter int N_IN    = 4,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(N_CELLS),
  localparam int OP_W   = 2 + 2 * IDX_W,
  localparam int AREA_W = $clog2(N_CELLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [N_IN-1:0]   load_data_i,
  input  logic              cnt_clr_i,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [OP_W-1:0]   op_word_i,
  output logic              rd_valid_o,
  output logic              rd_data_o,
  output logic [CNT_W-1:0]  pulse_cnt_o,
  output logic [AREA_W-1:0] area_o
);
  logic [IDX_W-1:0] p_idx, q_idx;
  logic             clr_op, imp_op, rd_op, pulse;

  // parallel load owns the bank for its cycle
  assign op_ready_o = !load_en_i;

  imply_decode #(.IDX_W(IDX_W)) u_dec (
    .op_valid_i (op_valid_i),
    .op_ready_i (op_ready_o),
    .op_word_i  (op_word_i),
    .p_idx_o    (p_idx),
    .q_idx_o    (q_idx),
    .clr_o      (clr_op),
    .imp_o      (imp_op),
    .rd_o       (rd_op),
    .pulse_o    (pulse)
  );

  imply_bank #(.N_CELLS(N_CELLS), .N_IN(N_IN)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en_i),
    .load_data_i (load_data_i),
    .clr_i       (clr_op),
    .imp_i       (imp_op),
    .rd_i        (rd_op),
    .p_idx_i     (p_idx),
    .q_idx_i     (q_idx),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  imply_meter #(.N_CELLS(N_CELLS), .N_IN(N_IN), .CNT_W(CNT_W)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_clr_i   (cnt_clr_i),
    .pulse_i     (pulse),
    .q_idx_i     (q_idx),
    .pulse_cnt_o (pulse_cnt_o),
    .area_o      (area_o)
  );

  p_rd_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_op |=> rd_valid_o);

  p_rd_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_op |=> !rd_valid_o);

  p_load_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> $stable(pulse_cnt_o) || $past(cnt_clr_i));
endmodule

// File: tb/imply_exec_tb.sv
`timescale 1ns/1ps
module imply_exec_tb;
  localparam logic [1:0] C_NOP = 2'b00, C_CLR = 2'b01, C_IMP = 2'b10, C_RD = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [3:0]  load_data = '0;
  logic        cnt_clr = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [9:0]  op_word = '0;
  logic        rd_valid, rd_data;
  logic [15:0] pulse_cnt;
  logic [4:0]  area;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  imply_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_data_i(load_data),
    .cnt_clr_i(cnt_clr), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .op_word_i(op_word), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .pulse_cnt_o(pulse_cnt), .area_o(area)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] c, input int p, input int q);
    op_valid = 1'b1;
    op_word  = {c, 4'(p), 4'(q)};
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rd(input int idx, output logic v);
    op(C_RD, 0, idx);
    v = rd_data;
  endtask

  task automatic load(input logic [3:0] d);
    load_en = 1'b1;
    load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic clr_cnt();
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic v;
    int ones = 0;
    check(pulse_cnt == 0, "R1 pulse", pulse_cnt, 0);
    check(area == 4, "R1 area", area, 4);
    check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    check(op_ready == 1, "R1 ready", op_ready, 1);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      ones += v;
    end
    check(ones == 0, "R1 cells", ones, 0);
  endtask

  task automatic t_read_nop();
    logic v;
    op(C_CLR, 0, 5);
    op(C_IMP, 5, 6);
    clr_cnt();
    op(C_RD, 0, 6);
    check(rd_valid == 1 && rd_data == 1, "R6 read", {rd_valid, rd_data}, 3);
    @(negedge clk);
    check(rd_valid == 0, "R6 one cycle", rd_valid, 0);
    op(C_NOP, 0, 6);
    op(C_NOP, 6, 6);
    rd(6, v);
    check(v == 1, "R5 nop keeps", v, 1);
    rd(5, v);
    check(v == 0, "R5 read keeps", v, 0);
    check(pulse_cnt == 0, "R5 no pulses", pulse_cnt, 0);
  endtask

  task automatic t_false_imply();
    logic v;
    for (int pv = 0; pv < 2; pv++)
      for (int qv = 0; qv < 2; qv++) begin
        load(4'(pv));
        op(C_CLR, 0, 9);
        op(C_CLR, 0, 8);
        rd(8, v);
        check(v == 0, "R2 clear", v, 0);
        if (qv == 1) op(C_IMP, 9, 8);
        clr_cnt();
        op(C_IMP, 0, 8);
        check(pulse_cnt == 1, "R7 step", pulse_cnt, 1);
        rd(8, v);
        check(v == ((pv == 0) || (qv == 1)), "R3 target", v, (pv == 0) || (qv == 1));
        rd(0, v);
        check(v == pv, "R3 source", v, pv);
      end
  endtask

  task automatic t_self();
    logic v;
    op(C_CLR, 0, 7);
    op(C_IMP, 7, 7);
    rd(7, v);
    check(v == 1, "R4 from 0", v, 1);
    op(C_IMP, 7, 7);
    rd(7, v);
    check(v == 1, "R4 from 1", v, 1);
  endtask

  task automatic t_load_block();
    logic v;
    op(C_CLR, 0, 9);
    op(C_IMP, 9, 5);
    clr_cnt();
    load_en = 1'b1;
    load_data = 4'b1010;
    op_valid = 1'b1;
    op_word = {C_CLR, 4'd0, 4'd5};
    #1;
    check(op_ready == 0, "R11 ready low", op_ready, 0);
    @(negedge clk);
    load_en = 1'b0;
    op_valid = 1'b0;
    check(pulse_cnt == 0, "R11 no pulse", pulse_cnt, 0);
    rd(5, v);
    check(v == 1, "R11 op blocked", v, 1);
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      check(v == ((4'b1010 >> i) & 1), "R11 load bit", v, (4'b1010 >> i) & 1);
    end
  endtask

  task automatic t_area();
    clr_cnt();
    check(area == 4, "R10 base", area, 4);
    op(C_CLR, 0, 6);
    op(C_CLR, 0, 6);
    op(C_IMP, 0, 9);
    op(C_CLR, 0, 2);
    check(area == 6, "R10 distinct", area, 6);
    op(C_IMP, 0, 15);
    check(area == 7, "R10 top cell", area, 7);
    check(pulse_cnt == 5, "R7 count", pulse_cnt, 5);
  endtask

  task automatic t_programs();
    logic v;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        load({2'b00, 1'(b), 1'(a)});
        clr_cnt();
        op(C_CLR, 0, 4); op(C_IMP, 0, 4);
        rd(4, v);
        check(v == !a, "R12 NOT", v, !a);
        check(pulse_cnt == 2, "R12 NOT pulses", pulse_cnt, 2);
        clr_cnt();
        op(C_CLR, 0, 4); op(C_IMP, 0, 4); op(C_IMP, 1, 4);
        rd(4, v);
        check(v == !(a && b), "R12 NAND", v, !(a && b));
        check(pulse_cnt == 3, "R12 NAND pulses", pulse_cnt, 3);
        clr_cnt();
        op(C_CLR, 0, 4); op(C_IMP, 0, 4);
        op(C_CLR, 0, 5); op(C_IMP, 1, 5);
        op(C_CLR, 0, 6); op(C_IMP, 4, 6); op(C_IMP, 5, 6);
        rd(6, v);
        check(v == (a || b), "R12 OR", v, a || b);
        check(pulse_cnt == 7, "R12 OR pulses", pulse_cnt, 7);
        clr_cnt();
        op(C_CLR, 0, 4); op(C_IMP, 0, 4); op(C_IMP, 1, 4);
        op(C_CLR, 0, 5); op(C_IMP, 0, 5);
        op(C_CLR, 0, 6); op(C_IMP, 1, 6);
        op(C_IMP, 4, 5); op(C_IMP, 4, 6);
        op(C_CLR, 0, 7); op(C_IMP, 5, 7); op(C_IMP, 6, 7);
        rd(7, v);
        check(v == (a != b), "R12 XOR", v, a != b);
        check(pulse_cnt == 12, "R12 XOR pulses", pulse_cnt, 12);
        check(area == 8, "R10 XOR area", area, 8);
      end
  endtask

  task automatic t_saturate();
    clr_cnt();
    op_valid = 1'b1;
    op_word = {C_CLR, 4'd0, 4'd4};
    repeat (65534) @(negedge clk);
    check(pulse_cnt == 65534, "R7 long run", pulse_cnt, 65534);
    repeat (4) @(negedge clk);
    op_valid = 1'b0;
    check(pulse_cnt == 65535, "R8 saturate", pulse_cnt, 65535);
    clr_cnt();
    check(pulse_cnt == 0, "R9 clear count", pulse_cnt, 0);
    check(area == 4, "R9 clear area", area, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_nop();
    t_false_imply();
    t_self();
    t_load_block();
    t_area();
    t_programs();
    t_saturate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule